// File: doc/BRIEF.md
# Staged Crosspoint Route Selector

This block routes seventeen single-bit data inputs onto seventeen data outputs. Each output is driven by its own selector, which picks exactly one input. Any one input may feed as many outputs as needed. The data path has no register, so the inputs can carry any pattern at any rate.

The route selections are held in two register levels. A host writes selections one at a time through an asynchronous microprocessor-style port into a pending level. A configure strobe then copies every pending selection into the live level at once, so that a whole new routing map takes effect in a single step. If the configure strobe is held high, each write also goes straight into the live level.

All strobe, address and data pins of the host port are first brought into the system clock domain through a short synchroniser. The strobe edges are detected in that domain. Sixteen more slots above the output range can be written and read back, but they drive no pin. A selection code that names no input is stored, and the output it governs is then held low.

Top module: `xpt_route_switch`

## Requirements
- R1: For a live selection code s below 17, output o equals data input s, with no clock delay.
- R2: The same input may be selected by several outputs at once, and all of them follow it.
- R3: A selection is written on a rising edge of `host_wr_n` while `host_cs_n` is low. The slot is given by the address value and the selection by `host_din`, both as plain binary. A rising edge of `host_wr_n` while `host_cs_n` is high writes nothing.
- R4: When `host_cfg` is low, a write changes only the pending level, and the routing does not change.
- R5: While `host_cfg` is high and `host_cs_n` is low, every pending selection is copied into the live level. A `host_cfg` pulse while `host_cs_n` is high copies nothing.
- R6: While `host_cfg` is high, a write updates the live selection of its slot in the same cycle as the pending one, so the route changes without a separate commit.
- R7: While `host_rd_n` and `host_cs_n` are both low, `host_doe` is high and `host_dout` carries the pending selection of the addressed slot. Otherwise `host_doe` is low.
- R8: Slots 0 to 16 drive outputs 0 to 16. Slots 17 to 32 can be written and read back but drive no output. A write to an address from 33 to 63 changes nothing, and a read of such an address returns 0.
- R9: A selection code from 17 to 31 is stored as written and reads back unchanged, while the output it governs is driven to 0.
- R10: While `host_ale` is high, the internal address follows the address bus. While `host_ale` is low, the internal address holds its last value for both writes and reads.
- R11: After reset, every pending and live slot holds code 31, so all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 6 | Slot address bus |
| host_din | input | 5 | Write data (input selection code) |
| host_dout | output | 5 | Readback data |
| host_doe | output | 1 | Readback data valid / bus drive enable |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| host_rd_n | input | 1 | Read strobe, active low |
| host_ale | input | 1 | Address latch enable, address follows bus while high |
| host_cfg | input | 1 | Configure strobe, active high |
| data_in | input | 17 | Data inputs |
| data_out | output | 17 | Data outputs |

## Verification
The assertions check, on every cycle, the behaviour of the register levels. A write lands in the pending slot it addressed. A commit makes the live level a copy of the pending one. The live level holds still when there is neither a commit nor a pass-through write. The readback drive appears only after a chip-selected read. The bench shows what only whole scenarios can prove: routing under every rotation of the selection map, fan-out, and the staging order of write, then configure, then route. It also covers the ignored writes and commits when chip select is high, the held address when the latch enable is low, out-of-range codes and addresses, and readback of every slot.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int ADDR_W = 6;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_RESET = '1;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_r [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_r[s] <= RST_VAL;
        else        stage_r[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_r[s] <= RST_VAL;
        else        stage_r[s] <= stage_r[s-1];
      end
    end
  end

  assign q = stage_r[STAGES-1];
endmodule

// File: rtl/xpt_sel_bank.sv
module xpt_sel_bank #(
  parameter int N_SLOT = 33,
  parameter int AW     = 6,
  parameter int DW     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_evt,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_code,
  input  logic                       commit,
  input  logic                       pass_thru,
  input  logic                       rd_en,
  input  logic [AW-1:0]              rd_addr,
  output logic [N_SLOT-1:0][DW-1:0]  live_sel,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid
);
  logic [N_SLOT-1:0][DW-1:0] pend_r;
  logic [N_SLOT-1:0][DW-1:0] live_r;
  logic wr_hit;
  logic rd_hit;

  assign wr_hit = wr_evt && (32'(wr_addr) < N_SLOT);
  assign rd_hit = 32'(rd_addr) < N_SLOT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_r <= {N_SLOT{xpt_pkg::CODE_RESET}};
      live_r <= {N_SLOT{xpt_pkg::CODE_RESET}};
    end else begin
      if (commit) live_r <= pend_r;
      if (wr_hit) begin
        pend_r[wr_addr] <= wr_code;
        if (pass_thru) live_r[wr_addr] <= wr_code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_hit ? pend_r[rd_addr] : '0;
      else       rd_data <= '0;
    end
  end

  assign live_sel = live_r;

  // R3
  pend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (pend_r[$past(wr_addr)] == $past(wr_code)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(pend_r));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_hit && pass_thru)) |=> (live_r == $past(pend_r)));

  // R4
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(wr_hit && pass_thru)) |=> $stable(live_r));

  // R8
  rd_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == '0));
endmodule

// File: rtl/xpt_mux_slice.sv
module xpt_mux_slice #(
  parameter int N_IN = 17,
  parameter int DW   = 5
) (
  input  logic [N_IN-1:0] din,
  input  logic [DW-1:0]   sel,
  output logic            y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel == DW'(i)) y = din[i];
    end
  end
endmodule

// File: rtl/xpt_route_switch.sv
module xpt_route_switch #(
  parameter int N_IN        = 17,
  parameter int N_OUT       = 17,
  parameter int N_SLOT      = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [xpt_pkg::ADDR_W-1:0] host_addr,
  input  logic [xpt_pkg::CODE_W-1:0] host_din,
  output logic [xpt_pkg::CODE_W-1:0] host_dout,
  output logic                       host_doe,
  input  logic                       host_cs_n,
  input  logic                       host_wr_n,
  input  logic                       host_rd_n,
  input  logic                       host_ale,
  input  logic                       host_cfg,
  input  logic [N_IN-1:0]            data_in,
  output logic [N_OUT-1:0]           data_out
);
  localparam int AW     = xpt_pkg::ADDR_W;
  localparam int DW     = xpt_pkg::CODE_W;
  localparam int CTRL_W = 5;
  localparam int BUS_W  = AW + DW;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b11100;

  logic [CTRL_W-1:0] ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic cs_s, wr_s, rd_s, ale_s, cfg_s;
  logic wr_q;
  logic [AW-1:0] addr_s, addr_lat;
  logic [DW-1:0] code_s;
  logic wr_evt, commit, rd_en;
  logic [N_SLOT-1:0][DW-1:0] live_sel;

  xpt_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_wr_n, host_rd_n, host_ale, host_cfg}),
    .q(ctrl_s)
  );

  xpt_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_addr, host_din}),
    .q(bus_s)
  );

  assign {cs_s, wr_s, rd_s, ale_s, cfg_s} = ctrl_s;
  assign {addr_s, code_s} = bus_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      addr_lat <= '0;
    end else begin
      wr_q <= wr_s;
      if (ale_s) addr_lat <= addr_s;
    end
  end

  assign wr_evt = wr_s && !wr_q && !cs_s;
  assign commit = cfg_s && !cs_s;
  assign rd_en  = !rd_s && !cs_s;

  xpt_sel_bank #(.N_SLOT(N_SLOT), .AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_evt(wr_evt), .wr_addr(addr_lat), .wr_code(code_s),
    .commit(commit), .pass_thru(cfg_s),
    .rd_en(rd_en), .rd_addr(addr_lat),
    .live_sel(live_sel), .rd_data(host_dout), .rd_valid(host_doe)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    xpt_mux_slice #(.N_IN(N_IN), .DW(DW)) u_slice (
      .din(data_in), .sel(live_sel[o]), .y(data_out[o])
    );
  end

  // R7
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> $past(!rd_s && !cs_s));

  // R3
  cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(live_sel[0]) || $past(cfg_s));
endmodule

// File: tb/xpt_route_switch_test.sv
module xpt_route_switch_test;
  localparam int NI = 17;
  localparam int NO = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] host_addr = '0;
  logic [4:0] host_din = '0;
  logic [4:0] host_dout;
  logic host_doe;
  logic host_cs_n = 1'b1, host_wr_n = 1'b1, host_rd_n = 1'b1;
  logic host_ale = 1'b1, host_cfg = 1'b0;
  logic [NI-1:0] data_in = '0;
  logic [NO-1:0] data_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xpt_route_switch uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe),
    .host_cs_n(host_cs_n), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .host_ale(host_ale), .host_cfg(host_cfg),
    .data_in(data_in), .data_out(data_out)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input int a, input int d, input bit use_cs);
    host_addr = 6'(a);
    host_din  = 5'(d);
    host_cs_n = !use_cs;
    tick(3);
    host_wr_n = 1'b0;
    tick(3);
    host_wr_n = 1'b1;
    tick(4);
    host_cs_n = 1'b1;
    tick(4);
  endtask

  task automatic host_read(input int a, output int d, output int oe);
    host_addr = 6'(a);
    host_cs_n = 1'b0;
    host_rd_n = 1'b0;
    tick(6);
    d  = int'(host_dout);
    oe = int'(host_doe);
    host_rd_n = 1'b1;
    host_cs_n = 1'b1;
    tick(4);
  endtask

  task automatic host_commit(input bit use_cs);
    host_cs_n = !use_cs;
    tick(2);
    host_cfg = 1'b1;
    tick(4);
    host_cfg = 1'b0;
    tick(4);
    host_cs_n = 1'b1;
    tick(3);
  endtask

  function automatic int route(input int sel, input logic [NI-1:0] din);
    return (sel < NI) ? int'(din[sel]) : 0;
  endfunction

  task automatic check_routes(input string req, input int sel [NO]);
    logic [NI-1:0] pats [4];
    pats[0] = '1;
    pats[1] = 17'h0AAAA;
    pats[2] = 17'h15555;
    pats[3] = 17'h0F0F3;
    for (int p = 0; p < 4; p++) begin
      data_in = pats[p];
      #1;
      for (int o = 0; o < NO; o++)
        check(req, int'(data_out[o]), route(sel[o], pats[p]));
    end
  endtask

  int sel_exp [NO];
  int rd_v, rd_oe;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R11: reset state, all outputs low, all slots read 31
    check("R7 idle doe", int'(host_doe), 0);
    for (int o = 0; o < NO; o++) sel_exp[o] = 31;
    check_routes("R11", sel_exp);
    for (int s = 0; s < 33; s++) begin
      host_read(s, rd_v, rd_oe);
      check("R11 readback", rd_v, 31);
      check("R7 doe", rd_oe, 1);
    end
    check("R7 doe after read", int'(host_doe), 0);

    // R1 / R4: rotation sweep over all inputs
    for (int p = 0; p < NI; p++) begin
      for (int o = 0; o < NO; o++) host_write(o, (o + p) % NI, 1'b1);
      // R4: nothing changed before commit
      check_routes("R4", sel_exp);
      if (p == 1) begin
        for (int o = 0; o < NO; o++) begin
          host_read(o, rd_v, rd_oe);
          check("R7 pending readback", rd_v, (o + 1) % NI);
        end
      end
      host_commit(1'b1);
      for (int o = 0; o < NO; o++) sel_exp[o] = (o + p) % NI;
      check_routes("R1", sel_exp);
    end

    // R2: fan-out of input 3 to all outputs
    for (int o = 0; o < NO; o++) host_write(o, 3, 1'b1);
    host_commit(1'b1);
    for (int o = 0; o < NO; o++) sel_exp[o] = 3;
    check_routes("R2", sel_exp);
    data_in = 17'h00008; #1;
    check("R2 all high", int'(data_out), 17'h1FFFF);
    data_in = ~17'h00008; #1;
    check("R2 all low", int'(data_out), 0);

    // R3: write with chip select high is dropped
    host_write(0, 5, 1'b0);
    host_read(0, rd_v, rd_oe);
    check("R3 no write", rd_v, 3);
    host_commit(1'b1);
    check_routes("R3", sel_exp);

    // R5: commit with chip select high is dropped
    host_write(1, 7, 1'b1);
    host_commit(1'b0);
    check_routes("R5 no commit", sel_exp);
    host_commit(1'b1);
    sel_exp[1] = 7;
    check_routes("R5 commit", sel_exp);

    // R6: configure held high makes writes immediate
    host_cfg = 1'b1;
    tick(3);
    host_write(2, 9, 1'b1);
    sel_exp[2] = 9;
    check_routes("R6", sel_exp);
    host_cfg = 1'b0;
    tick(3);

    // R8: upper slots stored, out-of-range addresses ignored
    host_write(20, 11, 1'b1);
    host_write(32, 14, 1'b1);
    host_write(40, 4, 1'b1);
    host_commit(1'b1);
    host_read(20, rd_v, rd_oe);
    check("R8 slot20", rd_v, 11);
    host_read(32, rd_v, rd_oe);
    check("R8 slot32", rd_v, 14);
    host_read(40, rd_v, rd_oe);
    check("R8 addr40", rd_v, 0);
    check("R8 addr40 doe", rd_oe, 1);
    check_routes("R8 routes", sel_exp);

    // R9: code above input range stored, output low
    host_write(3, 25, 1'b1);
    host_commit(1'b1);
    sel_exp[3] = 25;
    check_routes("R9", sel_exp);
    host_read(3, rd_v, rd_oe);
    check("R9 readback", rd_v, 25);

    // R10: address held while latch enable low
    host_addr = 6'd5;
    tick(4);
    host_ale = 1'b0;
    tick(4);
    host_write(9, 12, 1'b1);
    host_read(9, rd_v, rd_oe);
    check("R10 held read", rd_v, 12);
    host_ale = 1'b1;
    tick(2);
    host_read(5, rd_v, rd_oe);
    check("R10 slot5", rd_v, 12);
    host_read(9, rd_v, rd_oe);
    check("R10 slot9", rd_v, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule